// File: doc/BRIEF.md
# Prescaled Two-Port Fan PWM Generator

This block drives fan PWM lines from one shared timing setup. A two-stage prescaler divides the input clock. The first stage is an even-step divider and the second is a power-of-two divider. Their combined ticks advance an 8-bit period counter, and one full count of that counter is one PWM cycle. Each output port compares the counter against its own rise and fall points. A port with its enable low holds its line low, which is how a fan is driven at zero duty.

All timing settings are held in shadow registers: the clock word, the rise points and the fall points. New values are taken only when the period counter wraps back to zero. Changing a setting mid-cycle therefore never shortens or splits a pulse. A global `run` input holds low to stop the block. While stopped, the prescaler and period counter keep their values, every line is forced low, and the shadow registers follow the inputs directly. When `run` returns high, counting resumes from the held position.

Top module: `fan_pwm_gen`

## Requirements
- R1: Clock word bits 7:4 hold an exponent E, and this stage divides by 2^E.
- R2: Clock word bits 3:0 hold a value L. This stage divides by 1 when L is 0 and by 2·L otherwise. One prescaled tick lasts (L-stage ratio × 2^E) clock cycles.
- R3: Clock word bits 15:8 hold P. A PWM cycle lasts P+1 ticks, so the output period is ratio·(P+1) clock cycles.
- R4: In the 32-bit duty word, port k takes its rise point from bits 16k+7:16k and its fall point from bits 16k+15:16k+8.
- R5: When rise < fall, the line is high for counter values from rise through fall-1. The high time is (fall-rise)·ratio cycles.
- R6: When fall is nonzero and smaller than rise, the line is high from rise through the end of the cycle and from 0 through fall-1.
- R7: A fall point of 0 keeps the line high from rise to the end of the cycle. Rise 0 with fall 0 keeps the line high for the whole cycle.
- R8: Equal nonzero rise and fall points keep the line low.
- R9: A port whose enable is low drives its line low from the next clock edge. The other port is unaffected.
- R10: While running, the clock word and duty word are adopted only at the clock edge where the counter wraps to zero. A pulse already in progress completes with its old length.
- R11: With `run` low, all lines go low at the next edge and both counters hold. After `run` returns high, the interrupted cycle continues from where it stopped.
- R12: While reset is asserted, and immediately after it, every line is low and the counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Global enable; low stops counting and forces lines low |
| clk_cfg | input | 16 | {period P, high exponent E, low divider L} |
| duty_cfg | input | 32 | Rise and fall points for both ports |
| port_en | input | 2 | Per-port output enable |
| pwm_out | output | 2 | PWM lines, registered |

## Verification
Each line is registered from the period counter, so its level follows the counter's value one clock edge later. Enable and `run` changes reach the line at the first edge after they are applied, and adopted settings take effect at the edge that wraps the counter. Steady-state checks sample at falling edges and measure high and low times from one rising edge of the line to the next, so the fixed one-edge offset cancels out. The directed checks count the exact number of samples after a stimulus: for example, three remaining high samples after a stop at count 1, and eight old-length samples after a mid-pulse change.

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
  parameter int PORTS = 2,
  parameter int CNT_W = 8,
  parameter int HI_W  = 4,
  parameter int LO_W  = 4,
  localparam int CFG_W  = LO_W + HI_W + CNT_W,
  localparam int DUTY_W = 2 * CNT_W * PORTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CFG_W-1:0]  clk_cfg,
  input  logic [DUTY_W-1:0] duty_cfg,
  input  logic [PORTS-1:0]  port_en,
  output logic [PORTS-1:0]  pwm_out
);
  localparam int PS_W = (1 << HI_W) - 1 + LO_W + 1;

  logic [CFG_W-1:0]  cfg_q;
  logic [DUTY_W-1:0] duty_q;
  logic [PS_W-1:0]   ps_cnt;
  logic [CNT_W-1:0]  cnt;
  logic [PORTS-1:0]  lvl;

  wire [LO_W-1:0]  lo_f  = cfg_q[LO_W-1:0];
  wire [HI_W-1:0]  hi_f  = cfg_q[LO_W +: HI_W];
  wire [CNT_W-1:0] per_f = cfg_q[LO_W+HI_W +: CNT_W];

  wire [PS_W-1:0] lo_ratio = (lo_f == '0) ? PS_W'(1) : PS_W'({lo_f, 1'b0});
  wire [PS_W-1:0] ps_lim   = (lo_ratio << hi_f) - PS_W'(1);

  wire tick = run && (ps_cnt >= ps_lim);
  wire wrap = tick && (cnt >= per_f);
  wire load = !run || wrap;

  function automatic logic level(input logic [CNT_W-1:0] c,
                                 input logic [CNT_W-1:0] r,
                                 input logic [CNT_W-1:0] f);
    if (f == '0)     return c >= r;
    else if (r < f)  return (c >= r) && (c < f);
    else if (r > f)  return (c >= r) || (c < f);
    else             return 1'b0;
  endfunction

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign lvl[p] = level(cnt, duty_q[2*CNT_W*p +: CNT_W],
                          duty_q[2*CNT_W*p + CNT_W +: CNT_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      duty_q  <= '0;
      ps_cnt  <= '0;
      cnt     <= '0;
      pwm_out <= '0;
    end else begin
      if (run) ps_cnt <= tick ? '0 : ps_cnt + PS_W'(1);
      if (tick) cnt <= wrap ? '0 : cnt + CNT_W'(1);
      if (load) begin
        cfg_q  <= clk_cfg;
        duty_q <= duty_cfg;
      end
      pwm_out <= {PORTS{run}} & port_en & lvl;
    end
  end
endmodule

// File: rtl/fan_pwm_gen_chk.sv
module fan_pwm_gen_chk #(
  parameter int PORTS = 2,
  parameter int CNT_W = 8,
  parameter int CFG_W = 16,
  parameter int DUTY_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic [PORTS-1:0]  port_en,
  input logic [PORTS-1:0]  pwm_out,
  input logic [CNT_W-1:0]  cnt,
  input logic              wrap,
  input logic [CFG_W-1:0]  cfg_q,
  input logic [DUTY_W-1:0] duty_q
);
  // R11
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pwm_out == '0);

  // R11
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));

  // R10
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !wrap |=> $stable(cfg_q) && $stable(duty_q));

  // R12
  reset_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pwm_out == '0 && cnt == '0);

  for (genvar p = 0; p < PORTS; p++) begin : g_chk
    // R9
    port_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en[p] |=> !pwm_out[p]);

    // R7
    full_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && port_en[p] && duty_q[2*CNT_W*p +: 2*CNT_W] == '0 |=> pwm_out[p]);
  end
endmodule

bind fan_pwm_gen fan_pwm_gen_chk #(
  .PORTS(PORTS), .CNT_W(CNT_W), .CFG_W(CFG_W), .DUTY_W(DUTY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .port_en(port_en),
  .pwm_out(pwm_out), .cnt(cnt), .wrap(wrap), .cfg_q(cfg_q), .duty_q(duty_q)
);

// File: tb/tb_fan_pwm_gen.sv
module tb_fan_pwm_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [15:0] clk_cfg = '0;
  logic [31:0] duty_cfg = '0;
  logic [1:0]  port_en = '0;
  logic [1:0]  pwm_out;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  fan_pwm_gen dut (
    .clk(clk), .rst_n(rst_n), .run(run), .clk_cfg(clk_cfg),
    .duty_cfg(duty_cfg), .port_en(port_en), .pwm_out(pwm_out)
  );

  // {clk_cfg, duty_cfg}
  localparam logic [47:0] VECS [6] = '{
    {16'h0900, 32'h0703_0400},
    {16'h0710, 32'h0206_0502},
    {16'h0403, 32'h0100_0301},
    {16'h0521, 32'h0003_0100},
    {16'h0332, 32'h0300_0201},
    {16'h0F00, 32'h010E_000A}
  };

  function automatic int ratio_of(input logic [15:0] c);
    int l;
    l = (c[3:0] == 0) ? 1 : 2 * int'(c[3:0]);
    return l << c[7:4];
  endfunction

  function automatic int ticks_high(input int r, input int f, input int p);
    if (f == 0)     return p + 1 - r;
    else if (r < f) return f - r;
    else if (r > f) return (p + 1 - r) + f;
    else            return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [15:0] c, input logic [31:0] d,
                          input logic [1:0] e);
    @(negedge clk);
    rst_n = 1'b0;
    run = 1'b0;
    clk_cfg = c;
    duty_cfg = d;
    port_en = e;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run = 1'b1;
  endtask

  task automatic wait_rise(input int p, output bit ok);
    logic prev;
    prev = pwm_out[p];
    ok = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!prev && pwm_out[p]) begin
        ok = 1'b1;
        return;
      end
      prev = pwm_out[p];
    end
  endtask

  task automatic count_phases(input int p, output int hi, output int lo);
    hi = 1;
    lo = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (pwm_out[p]) hi++;
      else break;
    end
    lo = 1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!pwm_out[p]) lo++;
      else break;
    end
  endtask

  task automatic measure(input int p, output int hi, output int per);
    bit ok;
    int lo;
    wait_rise(p, ok);
    if (!ok) begin
      hi = -1;
      per = -1;
      return;
    end
    count_phases(p, hi, lo);
    per = hi + lo;
  endtask

  task automatic count_level(input int p, input logic v, input int n,
                             output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[p] == v) cnt++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int hi, per, lo, n;
    bit ok;

    // R12: lines low while reset is held, even with run high and full-on duty
    run = 1'b1;
    port_en = 2'b11;
    duty_cfg = '0;
    clk_cfg = 16'h0900;
    repeat (3) @(negedge clk);
    check("R12 reset lines", int'(pwm_out), 0);
    run = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 after reset run low", int'(pwm_out), 0);

    // Table: R1 R2 R3 R4 R5 R6 R7
    foreach (VECS[v]) begin
      logic [15:0] c;
      logic [31:0] d;
      int rat, eper;
      c = VECS[v][47:32];
      d = VECS[v][31:0];
      rat = ratio_of(c);
      eper = rat * (int'(c[15:8]) + 1);
      do_reset(c, d, 2'b11);
      measure(0, hi, per);
      check("R1/R2/R5 port0 high", hi,
            rat * ticks_high(int'(d[7:0]), int'(d[15:8]), int'(c[15:8])));
      check("R3 port0 period", per, eper);
      measure(1, hi, per);
      check("R4/R6 port1 high", hi,
            rat * ticks_high(int'(d[23:16]), int'(d[31:24]), int'(c[15:8])));
      check("R3 port1 period", per, eper);
    end

    // R7 full on (port0), R8 equal points stay low (port1)
    do_reset(16'h0900, 32'h0505_0000, 2'b11);
    repeat (2) @(negedge clk);
    fork
      count_level(0, 1'b0, 30, n);
    join
    check("R7 full-on low samples", n, 0);
    count_level(1, 1'b1, 30, n);
    check("R8 equal points high samples", n, 0);

    // R9 disable port0, port1 keeps running
    do_reset(16'h0900, 32'h0400_0400, 2'b11);
    repeat (3) @(negedge clk);
    port_en = 2'b10;
    count_level(0, 1'b1, 25, n);
    check("R9 disabled port high samples", n, 0);
    measure(1, hi, per);
    check("R9 other port high", hi, 4);
    check("R9 other port period", per, 10);

    // R11 stop mid-pulse at count 1, then resume
    do_reset(16'h0900, 32'h0000_0400, 2'b01);
    wait_rise(0, ok);
    run = 1'b0;
    count_level(0, 1'b1, 20, n);
    check("R11 stopped high samples", n, 0);
    run = 1'b1;
    hi = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (pwm_out[0]) hi++;
      else break;
    end
    check("R11 remaining high after resume", hi, 3);

    // R10 change period and fall in mid-pulse
    do_reset(16'h0900, 32'h0000_0800, 2'b01);
    wait_rise(0, ok);
    clk_cfg = 16'h0500;
    duty_cfg = 32'h0000_0200;
    count_phases(0, hi, lo);
    check("R10 ongoing pulse keeps old high", hi, 8);
    check("R10 ongoing cycle keeps old period", hi + lo, 10);
    measure(0, hi, per);
    check("R10 new high", hi, 2);
    check("R10 new period", per, 6);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule